// File: doc/BRIEF.md
# Fault Latch and Soft-Start Sequencer

This block handles fault shutdown and soft start for a digital switching-regulator controller. A saturating up/down counter takes the place of the soft-start capacitor. The counter charges by a programmable step each cycle and discharges by a second programmable step. Three conditions together form the fault condition: an overcurrent trip, an undervoltage condition and a reference that is not good. A fault sets a latch that turns the power outputs off. The latch then asks for a discharge of the level. That discharge is held back until the level has reached the soft-start-complete mark, so a charge already under way always runs to its end first.

Once the level has discharged down to the restart floor, the latch and the discharge request clear and charging starts again. If the fault is still present at that moment, the latch stays set and the next discharge again waits for a complete charge. Repeated faults therefore cannot restart the converter faster than one full soft-start period.

The undervoltage condition comes from a hysteretic compare of a digital supply code. The compare uses one of two threshold pairs: a user pair or a default pair. The soft-start level also limits the PWM command. The command passed on is the smaller of the requested command and the level.

Top module: `softstart_fault_seq`

## Requirements
- R1: The fault condition is `oc_trip OR undervoltage OR NOT ref_ok`. When it is present at a rising clock edge, `fault_latched` reads 1 after that edge.
- R2: `out_en` is 0 in every cycle in which `fault_latched` is 1, and 1 otherwise.
- R3: While the latch is set, the level keeps charging and no discharge begins until the level has reached `DONE_LVL` (default 240).
- R4: While discharging, the level falls until it is at or below `RESTART_LVL` (default 80). At the next edge the latch clears, the discharge stops and the level holds for that one cycle. Charging resumes after that cycle.
- R5: The level saturates. Charging never carries it past 2^LVL_W-1 (255 by default), where it then stays, and discharging never takes it below 0.
- R6: After reset the latch is set, the level is 0, `out_en` is 0 and the undervoltage condition is asserted.
- R7: Undervoltage clears at an edge where the supply code is at or above the on threshold. It sets at an edge where the code is below the off threshold. Between the two thresholds it keeps its state. With `thr_default`=0 the thresholds are 120/100; with `thr_default`=1 they are 224/144. The compare is registered, so it adds one cycle before the latch sees a change.
- R8: A fault still present when the floor is reached keeps the latch set. The level then charges again to `DONE_LVL` before the next discharge, and `out_en` stays 0 for the whole time.
- R9: `cmd_out` equals the smaller of `cmd_in` and the current level.
- R10: Each cycle that charges adds `chg_step` to the level, and each cycle that discharges subtracts `dis_step`, with saturation as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oc_trip | input | 1 | Overcurrent trip |
| ref_ok | input | 1 | Reference-good flag |
| supply_code | input | SUP_W | Digital supply measurement |
| thr_default | input | 1 | 1 selects the default undervoltage thresholds, 0 the user pair |
| chg_step | input | STEP_W | Level increment per charging cycle |
| dis_step | input | STEP_W | Level decrement per discharging cycle |
| cmd_in | input | LVL_W | Requested PWM command |
| ss_level | output | LVL_W | Soft-start level |
| cmd_out | output | LVL_W | Command limited by the soft-start level |
| fault_latched | output | 1 | Fault latch state |
| out_en | output | 1 | Power-output enable |

## Verification
Some properties are checked by assertions on every cycle. These are: a fault always sets the latch at the next edge; a discharge starts only from a level at or above the complete mark; the latch releases only from a level at or below the floor; the enable stays off during a discharge; the level never falls while charging; the command limit holds; and undervoltage changes only across the proper threshold. Other behaviours need the bench's scenarios to show them. These are: the full charge–discharge–recharge sequence under a persistent fault, the hysteresis band of each threshold pair, saturation at full scale, and the exact step arithmetic under random rates. The bench compares these against a cycle model it builds from the requirements.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

   typedef enum logic {
      UV_SEL_USER    = 1'b0,
      UV_SEL_DEFAULT = 1'b1
   } uv_sel_e;

   typedef struct packed {
      logic overcurrent;
      logic undervolt;
      logic ref_bad;
   } fault_src_t;

endpackage

// File: rtl/ss_uv_hyst.sv
module ss_uv_hyst
   import ss_seq_pkg::*;
#(
   parameter int SUP_W   = 8,
   parameter int USR_ON  = 120,
   parameter int USR_OFF = 100,
   parameter int DEF_ON  = 224,
   parameter int DEF_OFF = 144
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUP_W-1:0] supply,
   input  logic             use_default,
   output logic             uv_low
);

   localparam logic [SUP_W-1:0] USR_ON_C  = SUP_W'(USR_ON);
   localparam logic [SUP_W-1:0] USR_OFF_C = SUP_W'(USR_OFF);
   localparam logic [SUP_W-1:0] DEF_ON_C  = SUP_W'(DEF_ON);
   localparam logic [SUP_W-1:0] DEF_OFF_C = SUP_W'(DEF_OFF);

   uv_sel_e          sel;
   logic [SUP_W-1:0] on_thr;
   logic [SUP_W-1:0] off_thr;

   assign sel = use_default ? UV_SEL_DEFAULT : UV_SEL_USER;

   always_comb begin
      case (sel)
         UV_SEL_DEFAULT: begin
            on_thr  = DEF_ON_C;
            off_thr = DEF_OFF_C;
         end
         default: begin
            on_thr  = USR_ON_C;
            off_thr = USR_OFF_C;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uv_low <= 1'b1;
      end else if (uv_low && (supply >= on_thr)) begin
         uv_low <= 1'b0;
      end else if (!uv_low && (supply < off_thr)) begin
         uv_low <= 1'b1;
      end
   end

   // R7: leaving undervoltage needs a code at or above the on threshold
   a_r7_clear_at_on: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(uv_low) |-> ($past(supply) >= $past(on_thr)));

   // R7: entering undervoltage needs a code below the off threshold
   a_r7_set_below_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_low) |-> ($past(supply) < $past(off_thr)));

endmodule

// File: rtl/ss_level_ctr.sv
module ss_level_ctr #(
   parameter int LVL_W  = 8,
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              discharge,
   input  logic              hold,
   input  logic [STEP_W-1:0] chg_step,
   input  logic [STEP_W-1:0] dis_step,
   output logic [LVL_W-1:0]  level
);

   localparam int EXT_W = ((LVL_W > STEP_W) ? LVL_W : STEP_W) + 1;
   localparam logic [EXT_W-1:0] FULL_X = EXT_W'({LVL_W{1'b1}});

   logic [EXT_W-1:0] lvl_x;
   logic [EXT_W-1:0] up_x;
   logic [EXT_W-1:0] dstep_x;
   logic [LVL_W-1:0] dn_l;
   logic [LVL_W-1:0] nxt;

   assign lvl_x   = EXT_W'(level);
   assign dstep_x = EXT_W'(dis_step);
   assign up_x    = lvl_x + EXT_W'(chg_step);
   assign dn_l    = level - LVL_W'(dis_step);

   always_comb begin
      if (hold) begin
         nxt = level;
      end else if (discharge) begin
         nxt = (dstep_x > lvl_x) ? '0 : dn_l;
      end else begin
         nxt = (up_x > FULL_X) ? FULL_X[LVL_W-1:0] : up_x[LVL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         level <= nxt;
      end
   end

   // R5: charging never makes the level go down (no wrap at full scale)
   a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (!discharge && !hold) |=> (level >= $past(level)));

   // R5: discharging never makes the level go up (no wrap at zero)
   a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      (discharge && !hold) |=> (level <= $past(level)));

   // R4: the release cycle leaves the level unchanged
   a_r4_hold_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(level));

endmodule

// File: rtl/ss_fault_latch.sv
module ss_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_in,
   input  logic ss_done,
   input  logic at_floor,
   output logic fault_q,
   output logic dis_q,
   output logic release_now
);

   assign release_now = dis_q && at_floor;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= 1'b1;
         dis_q   <= 1'b0;
      end else begin
         fault_q <= fault_in || (fault_q && !release_now);
         if (release_now) begin
            dis_q <= 1'b0;
         end else if (fault_q && ss_done) begin
            dis_q <= 1'b1;
         end
      end
   end

   // R1: any fault present at an edge leaves the latch set
   a_r1_fault_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in |=> fault_q);

   // R3: the discharge request only exists while the latch is or was set
   a_r3_discharge_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_q) |-> $past(fault_q));

endmodule

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq
   import ss_seq_pkg::*;
#(
   parameter int LVL_W       = 8,
   parameter int STEP_W      = 4,
   parameter int SUP_W       = 8,
   parameter int DONE_LVL    = 240,
   parameter int RESTART_LVL = 80,
   parameter int UV_USR_ON   = 120,
   parameter int UV_USR_OFF  = 100,
   parameter int UV_DEF_ON   = 224,
   parameter int UV_DEF_OFF  = 144
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oc_trip,
   input  logic              ref_ok,
   input  logic [SUP_W-1:0]  supply_code,
   input  logic              thr_default,
   input  logic [STEP_W-1:0] chg_step,
   input  logic [STEP_W-1:0] dis_step,
   input  logic [LVL_W-1:0]  cmd_in,
   output logic [LVL_W-1:0]  ss_level,
   output logic [LVL_W-1:0]  cmd_out,
   output logic              fault_latched,
   output logic              out_en
);

   localparam logic [LVL_W-1:0] DONE_C    = LVL_W'(DONE_LVL);
   localparam logic [LVL_W-1:0] RESTART_C = LVL_W'(RESTART_LVL);

   initial begin
      if (LVL_W < 2 || LVL_W > 24 || STEP_W < 1 || SUP_W < 2 || SUP_W > 24)
         $fatal(1, "softstart_fault_seq: width parameter out of range");
      if (!(RESTART_LVL >= 0 && RESTART_LVL < DONE_LVL && DONE_LVL < (1 << LVL_W)))
         $fatal(1, "softstart_fault_seq: need 0 <= RESTART_LVL < DONE_LVL < full scale");
      if (!(UV_USR_OFF < UV_USR_ON && UV_DEF_OFF < UV_DEF_ON && UV_USR_ON < (1 << SUP_W)
            && UV_DEF_ON < (1 << SUP_W)))
         $fatal(1, "softstart_fault_seq: undervoltage thresholds must satisfy off < on < full scale");
   end

   fault_src_t src;
   logic       uv_low;
   logic       fault_in;
   logic       ss_done;
   logic       at_floor;
   logic       dis_q;
   logic       release_now;

   ss_uv_hyst #(
      .SUP_W   (SUP_W),
      .USR_ON  (UV_USR_ON),
      .USR_OFF (UV_USR_OFF),
      .DEF_ON  (UV_DEF_ON),
      .DEF_OFF (UV_DEF_OFF)
   ) u_uv (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply      (supply_code),
      .use_default (thr_default),
      .uv_low      (uv_low)
   );

   assign src.overcurrent = oc_trip;
   assign src.undervolt   = uv_low;
   assign src.ref_bad     = !ref_ok;
   assign fault_in        = |src;

   assign ss_done  = (ss_level >= DONE_C);
   assign at_floor = (ss_level <= RESTART_C);

   ss_fault_latch u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .fault_in    (fault_in),
      .ss_done     (ss_done),
      .at_floor    (at_floor),
      .fault_q     (fault_latched),
      .dis_q       (dis_q),
      .release_now (release_now)
   );

   ss_level_ctr #(
      .LVL_W  (LVL_W),
      .STEP_W (STEP_W)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .discharge (dis_q),
      .hold      (release_now),
      .chg_step  (chg_step),
      .dis_step  (dis_step),
      .level     (ss_level)
   );

   assign out_en  = !fault_latched;
   assign cmd_out = (cmd_in < ss_level) ? cmd_in : ss_level;

   // R3: a discharge only starts from a completed soft-start level
   a_r3_discharge_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_q) |-> ($past(ss_level) >= DONE_C));

   // R4: the latch only releases from a level at or below the floor
   a_r4_release_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_latched) |-> ($past(ss_level) <= RESTART_C));

   // R2: the outputs stay disabled while discharging
   a_r2_off_while_discharging: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q |-> !out_en);

   // R9: the command passed on never exceeds the level or the request
   a_r9_cmd_limited: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out <= ss_level) && (cmd_out <= cmd_in));

endmodule

// File: tb/softstart_fault_seq_test.sv
`timescale 1ns/1ps
module softstart_fault_seq_test;

   localparam int LW    = 8;
   localparam int SW    = 4;
   localparam int PW    = 8;
   localparam int DONE  = 240;
   localparam int FLOOR = 80;
   localparam int FULL  = 255;
   localparam int U_ON  = 120;
   localparam int U_OFF = 100;
   localparam int D_ON  = 224;
   localparam int D_OFF = 144;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          oc_trip;
   logic          ref_ok;
   logic [PW-1:0] supply_code;
   logic          thr_default;
   logic [SW-1:0] chg_step;
   logic [SW-1:0] dis_step;
   logic [LW-1:0] cmd_in;
   logic [LW-1:0] ss_level;
   logic [LW-1:0] cmd_out;
   logic          fault_latched;
   logic          out_en;

   always #2 clk = ~clk;

   softstart_fault_seq uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .oc_trip       (oc_trip),
      .ref_ok        (ref_ok),
      .supply_code   (supply_code),
      .thr_default   (thr_default),
      .chg_step      (chg_step),
      .dis_step      (dis_step),
      .cmd_in        (cmd_in),
      .ss_level      (ss_level),
      .cmd_out       (cmd_out),
      .fault_latched (fault_latched),
      .out_en        (out_en)
   );

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   // cycle model built from the requirements
   int m_lvl, m_fault, m_dis, m_uv;
   bit cmp_en = 0;

   function automatic int f_charge(int lvl, int st);
      return (lvl + st > FULL) ? FULL : lvl + st;        // R5, R10
   endfunction

   function automatic int f_discharge(int lvl, int st);
      return (st > lvl) ? 0 : lvl - st;                  // R5, R10
   endfunction

   function automatic int f_min(int a, int b);
      return (a < b) ? a : b;                            // R9
   endfunction

   always @(posedge clk) begin
      int n_lvl, n_dis, n_fault, n_uv, on_t, off_t, flt, rel;
      if (!rst_n) begin
         m_lvl = 0; m_fault = 1; m_dis = 0; m_uv = 1;    // R6
      end else begin
         flt   = (oc_trip || m_uv || !ref_ok) ? 1 : 0;   // R1
         rel   = (m_dis && m_lvl <= FLOOR) ? 1 : 0;      // R4
         on_t  = thr_default ? D_ON : U_ON;               // R7
         off_t = thr_default ? D_OFF : U_OFF;
         n_uv  = m_uv;
         if (m_uv && supply_code >= on_t) n_uv = 0;
         else if (!m_uv && supply_code < off_t) n_uv = 1;
         if (rel) n_lvl = m_lvl;
         else if (m_dis) n_lvl = f_discharge(m_lvl, dis_step);
         else n_lvl = f_charge(m_lvl, chg_step);
         if (rel) n_dis = 0;
         else if (m_fault && m_lvl >= DONE) n_dis = 1;   // R3
         else n_dis = m_dis;
         n_fault = (flt || (m_fault && !rel)) ? 1 : 0;   // R8
         m_lvl = n_lvl; m_dis = n_dis; m_fault = n_fault; m_uv = n_uv;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && rst_n && !done_flag) begin
         chk("R10 level step", int'(ss_level), m_lvl);
         chk("R1 fault latch", int'(fault_latched), m_fault);
         chk("R2 out_en", int'(out_en), m_fault ? 0 : 1);
         chk("R9 cmd_out", int'(cmd_out), f_min(int'(cmd_in), m_lvl));
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_enable(input int limit, output int seen);
      seen = 0;
      for (int i = 0; i < limit; i++) begin
         step();
         if (out_en) begin seen = 1; break; end
      end
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1..all actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seen, peak, prev, rises, en_hits;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; oc_trip = 1'b0; ref_ok = 1'b1; supply_code = '0;
      thr_default = 1'b0; chg_step = 4'd4; dis_step = 4'd4; cmd_in = 8'hFF;
      repeat (3) step();
      @(negedge clk);
      // R6 reset state
      chk("R6 level after reset", int'(ss_level), 0);
      chk("R6 latch after reset", int'(fault_latched), 1);
      chk("R6 out_en after reset", int'(out_en), 0);
      step();
      supply_code = 8'd200;
      rst_n = 1'b1;
      cmp_en = 1;

      // startup: full charge, discharge to floor, release (R3, R4)
      peak = 0; seen = 0;
      for (int i = 0; i < 400; i++) begin
         step();
         if (int'(ss_level) > peak) peak = int'(ss_level);
         if (out_en) begin seen = 1; break; end
      end
      @(negedge clk);
      chk("R4 enabled after restart", seen, 1);
      chk("R3 full charge before discharge", (peak >= DONE) ? 1 : 0, 1);
      chk("R4 level at floor on release", (int'(ss_level) <= FLOOR) ? 1 : 0, 1);

      // R5 saturation at full scale
      repeat (80) step();
      @(negedge clk);
      chk("R5 saturated at full scale", int'(ss_level), FULL);

      // R7 user band: 110 is inside the hysteresis band, no fault
      step(); supply_code = 8'd110;
      repeat (10) step();
      @(negedge clk);
      chk("R7 inside band keeps supply good", int'(fault_latched), 0);
      step(); supply_code = 8'd99;
      step(); step();
      @(negedge clk);
      chk("R7 below off threshold faults", int'(fault_latched), 1);
      step(); supply_code = 8'd110;
      repeat (300) step();
      @(negedge clk);
      chk("R7 band holds undervoltage", int'(fault_latched), 1);
      step(); supply_code = 8'd120;
      wait_enable(400, seen);
      @(negedge clk);
      chk("R7 on threshold clears", seen, 1);

      // R3 fault while level is low: charge continues first
      step(); oc_trip = 1'b1;
      step(); oc_trip = 1'b0;
      prev = int'(ss_level); rises = 0;
      for (int i = 0; i < 20; i++) begin
         step();
         if (int'(ss_level) > prev) rises++;
         prev = int'(ss_level);
      end
      @(negedge clk);
      chk("R3 level rises while latched below done", rises, 20);
      wait_enable(400, seen);

      // R8 persistent fault: repeated full cycles, outputs stay off
      step(); oc_trip = 1'b1;
      rises = 0; en_hits = 0; prev = int'(ss_level);
      for (int i = 0; i < 400; i++) begin
         step();
         if (out_en && i > 0) en_hits++;
         if (int'(ss_level) >= DONE && prev < DONE) rises++;
         prev = int'(ss_level);
      end
      @(negedge clk);
      chk("R8 outputs stay off under persistent fault", en_hits, 0);
      chk("R8 each restart recharges to done", (rises >= 2) ? 1 : 0, 1);
      step(); oc_trip = 1'b0;
      wait_enable(400, seen);

      // R7 default thresholds
      step(); thr_default = 1'b1; supply_code = 8'd200;
      repeat (20) step();
      @(negedge clk);
      chk("R7 default pair above off stays good", int'(out_en), 1);
      step(); supply_code = 8'd140;
      repeat (5) step();
      step(); supply_code = 8'd200;
      repeat (300) step();
      @(negedge clk);
      chk("R7 default band holds undervoltage", int'(fault_latched), 1);
      step(); supply_code = 8'd230;
      wait_enable(400, seen);
      @(negedge clk);
      chk("R7 default on threshold clears", seen, 1);

      // R10 ref_ok loss and odd step sizes
      step(); chg_step = 4'd7; dis_step = 4'd13; ref_ok = 1'b0;
      step(); ref_ok = 1'b1;
      wait_enable(400, seen);
      @(negedge clk);
      chk("R1 reference loss restart completes", seen, 1);

      // constrained random mix
      for (int i = 0; i < 6000; i++) begin
         step();
         oc_trip     = (($urandom % 48) == 0);
         ref_ok      = (($urandom % 90) != 0);
         supply_code = PW'(95 + ($urandom % 160));
         if ((i % 700) == 0) thr_default = ~thr_default;
         chg_step    = SW'($urandom);
         dis_step    = SW'($urandom);
         cmd_in      = LW'($urandom);
      end
      @(negedge clk);
      finish_run();
   end

endmodule